// File: doc/BRIEF.md
# Dual-Rate Bit Clock Recovery Loop

This block rebuilds a bit-rate timing clock from a hard-limited, already demodulated serial stream. The stream is oversampled. A single-cycle enable, `tickEn`, marks each sample point, and one bit lasts 64 such ticks. A 6-bit local phase counter runs through the bit. Each input transition is compared against the counter's nominal bit boundary, which is tick 0. The counter is then pulled toward the transition by a correction whose size depends on two static controls.

With `fastEn` high, a transition more than 4 ticks (22.5 degrees) away from the boundary triggers a large step, capped at the measured error. An error within that window gets a single-tick step. `lockSel` chooses how large the large step is. The setting 0 gives a big step and the fastest lock. The setting 1 gives a smaller step and lower jitter. The recovered clock `recClk` is high for the first half of the local bit. The retimed data `recData` is taken at mid-bit and changes only when `recClk` falls.

Top module: `bitclk_recovery`

## Requirements
- R1: After reset, `recClk` is 1 and `recData` is 0, and the local phase is tick 0. With no input transitions, `recClk` first falls on the 32nd tick and then falls once every 64 ticks. `recClk` is 1 while the phase is in ticks 0..31 and 0 while it is in ticks 32..63.
- R2: `recData` changes only in the tick where `recClk` falls. In that tick it takes the value that `rxIn` has in the same tick.
- R3: In a clock cycle with `tickEn` low, the phase, `recClk` and `recData` hold their values.
- R4: A transition is a tick whose `rxIn` differs from the value `rxIn` had in the previous tick. Its error is the local phase at that tick, read as a signed value in -32..31. A positive error moves the phase back by the correction. A negative error moves it forward. An error of 0 applies no correction.
- R5: With `fastEn` = 1 and an error magnitude above 4 ticks, the correction is 8 ticks when `lockSel` = 0 and 4 ticks when `lockSel` = 1. It is never larger than the error magnitude.
- R6: With `fastEn` = 0, or with an error magnitude of 4 ticks or less, the correction is 1 tick. The return to the slow rate happens at the first transition measured inside the window.
- R7: A bit period with no transition applies no correction. The next `recClk` fall follows the previous one by exactly 64 ticks.
- R8: With `fastEn` = 1, alternating data and any starting offset, the error reaches 4 ticks or less within 18 transitions when `lockSel` = 0 and within 50 transitions when `lockSel` = 1. It stays there while the input period remains 64 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Oversampling tick enable, 64 ticks per bit |
| rxIn | input | 1 | Hard-limited demodulated serial data |
| fastEn | input | 1 | 1 allows fast correction for large errors |
| lockSel | input | 1 | Fast step size: 0 gives 8 ticks, 1 gives 4 ticks |
| recClk | output | 1 | Recovered bit clock |
| recData | output | 1 | Retimed data, updated on the falling edge of `recClk` |

## Verification
The internal phase error is not visible at the ports. The bench recovers it from the port timing instead. The gap between the last `recClk` fall and a transition gives the error the loop measured. The gap from that transition to the next fall gives the correction it applied. Both are compared against the step rule.

The hardest cases are the extremes of the error range: +31 ticks and -32 ticks. The stimulus reaches them by timing the first transition after reset at tick 96 and at tick 97. From those starts the exact lock-in transition count is known for each mode. A random tail mixes in bits without transitions.

// File: rtl/brc_pkg.sv
package brc_pkg;
  // Ticks per bit is 2**PH_W.
  localparam int PH_W = 6;

  // Strobes from the loop control into the phase datapath.
  typedef struct packed {
    logic            tick;
    logic            adjust;
    logic            retard;
    logic [PH_W-1:0] amount;
  } corr_t;
endpackage

// File: rtl/brc_loop_ctrl.sv
module brc_loop_ctrl
  import brc_pkg::*;
#(
  parameter int THRESH     = 4,
  parameter int FAST_BIG   = 8,
  parameter int FAST_SMALL = 4,
  parameter int SLOW_STEP  = 1
) (
  input  logic            tickEn,
  input  logic            edgeSeen,
  input  logic [PH_W-1:0] phErr,
  input  logic            fastEn,
  input  logic            lockSel,
  output corr_t           ctrl
);
  localparam logic [PH_W-1:0] THRESH_V = PH_W'(THRESH);
  localparam logic [PH_W-1:0] BIG_V    = PH_W'(FAST_BIG);
  localparam logic [PH_W-1:0] SMALL_V  = PH_W'(FAST_SMALL);
  localparam logic [PH_W-1:0] SLOW_V   = PH_W'(SLOW_STEP);

  logic [PH_W-1:0] errMag;
  logic [PH_W-1:0] stepSel;
  logic            useFast;

  always_comb begin
    // Magnitude of the signed error; -32 maps to 32, which fits unsigned.
    errMag  = phErr[PH_W-1] ? (~phErr + PH_W'(1)) : phErr;
    useFast = fastEn && (errMag > THRESH_V);
    stepSel = useFast ? (lockSel ? SMALL_V : BIG_V) : SLOW_V;

    ctrl.tick   = tickEn;
    ctrl.adjust = tickEn && edgeSeen && (errMag != '0);
    ctrl.retard = ~phErr[PH_W-1];
    ctrl.amount = (errMag < stepSel) ? errMag : stepSel;
  end
endmodule

// File: rtl/brc_phase_path.sv
module brc_phase_path
  import brc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxIn,
  input  corr_t           ctrl,
  output logic [PH_W-1:0] phase,
  output logic            rxPrev,
  output logic            edgeSeen,
  output logic            recClk,
  output logic            recData
);
  localparam int MSB = PH_W - 1;

  logic [PH_W-1:0] phaseQ;
  logic [PH_W-1:0] phNext;
  logic [PH_W-1:0] delta;
  logic            rxPrevQ;
  logic            recDataQ;
  logic            fallNow;

  always_comb begin
    if (!ctrl.adjust)     delta = '0;
    else if (ctrl.retard) delta = ~ctrl.amount + PH_W'(1);
    else                  delta = ctrl.amount;
    phNext   = phaseQ + PH_W'(1) + delta;
    fallNow  = ~phaseQ[MSB] & phNext[MSB];
    edgeSeen = rxIn ^ rxPrevQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= '0;
      rxPrevQ  <= 1'b0;
      recDataQ <= 1'b0;
    end else if (ctrl.tick) begin
      phaseQ  <= phNext;
      rxPrevQ <= rxIn;
      if (fallNow) recDataQ <= rxIn;
    end
  end

  assign phase   = phaseQ;
  assign rxPrev  = rxPrevQ;
  assign recClk  = ~phaseQ[MSB];
  assign recData = recDataQ;
endmodule

// File: rtl/bitclk_recovery.sv
module bitclk_recovery
  import brc_pkg::*;
#(
  parameter int THRESH     = 4,
  parameter int FAST_BIG   = 8,
  parameter int FAST_SMALL = 4,
  parameter int SLOW_STEP  = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic rxIn,
  input  logic fastEn,
  input  logic lockSel,
  output logic recClk,
  output logic recData
);
  corr_t           corr;
  logic [PH_W-1:0] phaseQ;
  logic            rxPrevQ;
  logic            edgeSeen;

  brc_loop_ctrl #(
    .THRESH(THRESH), .FAST_BIG(FAST_BIG),
    .FAST_SMALL(FAST_SMALL), .SLOW_STEP(SLOW_STEP)
  ) ctrl_i (
    .tickEn(tickEn), .edgeSeen(edgeSeen), .phErr(phaseQ),
    .fastEn(fastEn), .lockSel(lockSel), .ctrl(corr)
  );

  brc_phase_path path_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .ctrl(corr),
    .phase(phaseQ), .rxPrev(rxPrevQ), .edgeSeen(edgeSeen),
    .recClk(recClk), .recData(recData)
  );
endmodule

// File: rtl/brc_checker.sv
module brc_checker
  import brc_pkg::*;
#(
  parameter int MAX_STEP = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            tickEn,
  input logic            rxIn,
  input logic            fastEn,
  input logic            recClk,
  input logic            recData,
  input logic [PH_W-1:0] phase,
  input logic            rxPrev
);
  localparam logic [PH_W-1:0] OFS  = PH_W'(MAX_STEP - 1);
  localparam logic [PH_W-1:0] SPAN = PH_W'(2 * MAX_STEP);

  // R3: idle cycles freeze everything
  p_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> ($stable(phase) && $stable(recClk) && $stable(recData)));

  // R2: retimed data moves only with a falling recovered clock
  p_data_at_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(recData) |-> $fell(recClk));

  // R5: no tick ever moves the phase by more than one step plus the advance
  p_step_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (PH_W'(phase - $past(phase) + OFS) <= SPAN));

  // R6: with slow-only correction the phase moves by 0, 1 or 2 ticks
  p_slow_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !fastEn) |=> (PH_W'(phase - $past(phase)) <= PH_W'(2)));

  // R7: a tick without a transition only advances the phase
  p_no_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && (rxIn == rxPrev)) |=> (PH_W'(phase - $past(phase)) == PH_W'(1)));
endmodule

bind bitclk_recovery brc_checker #(.MAX_STEP(FAST_BIG)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxIn(rxIn), .fastEn(fastEn),
  .recClk(recClk), .recData(recData), .phase(phaseQ), .rxPrev(rxPrevQ)
);

// File: tb/bitclk_recovery_tb_top.sv
module bitclk_recovery_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic rxIn = 1'b0;
  logic fastEn = 1'b0;
  logic lockSel = 1'b0;
  logic recClk, recData;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // monitor state
  int tickNo, lastFall, bitNo, lockAt;
  bit lastRx, prevClk, lost;
  int expQ[$];
  bit bits[200];

  always #2 clk = ~clk;

  bitclk_recovery dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxIn(rxIn),
    .fastEn(fastEn), .lockSel(lockSel), .recClk(recClk), .recData(recData)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (tick %0d)", tag, act, exp, tickNo);
    end
  endtask

  function automatic int corrOf(input int e, input bit f, input bit l);
    int mag, step;
    mag  = (e < 0) ? -e : e;
    step = (f && mag > 4) ? (l ? 4 : 8) : 1;
    if (step > mag) step = mag;
    return (e < 0) ? -step : step;
  endfunction

  // Monitor: samples after each posedge, derives error and correction from port timing
  always @(posedge clk) begin
    #1;
    if (rstN && tickEn) begin
      bit curRx, isEdge, fell;
      int e, c, j, pend;
      tickNo++;
      curRx  = rxIn;
      isEdge = (curRx != lastRx);
      lastRx = curRx;
      fell   = prevClk && !recClk;
      prevClk = recClk;
      pend = -1;
      if (isEdge && lastFall >= 0) begin
        e = (32 + tickNo - 1 - lastFall) % 64;
        if (e >= 32) e -= 64;
        c = corrOf(e, fastEn, lockSel);
        j = ((31 - e + c) % 64 + 64) % 64;
        if (j == 0) j = 64;
        pend = tickNo + j;
        bitNo++;
        if (lockAt == 0 && (e <= 4 && e >= -4)) lockAt = bitNo;
        else if (lockAt != 0 && (e > 4 || e < -4)) lost = 1;
      end
      if (fell) begin
        chk(recData == curRx, "R2 data at fall", recData, curRx);
        if (expQ.size() > 0) begin
          int ef;
          ef = expQ.pop_front();
          chk(tickNo == ef, "R4/R5/R6 fall after correction", tickNo, ef);
        end else if (lastFall >= 0)
          chk(tickNo - lastFall == 64, "R7 no-transition period", tickNo - lastFall, 64);
        else
          chk(tickNo == 32, "R1 first fall", tickNo, 32);
        lastFall = tickNo;
      end
      if (pend >= 0) expQ.push_back(pend);
    end
  end

  task automatic tickOnce(input bit r);
    @(negedge clk);
    rxIn = r;
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    if ($urandom_range(0, 7) == 0) repeat (2) @(negedge clk);
  endtask

  task automatic runScen(input bit f, input bit l, input int firstT, input int nBits,
                         input bit randTail, input int lockLimit, input int lockExact);
    int total;
    bit r;
    @(negedge clk);
    rstN = 1'b0; tickEn = 1'b0; rxIn = 1'b0; fastEn = f; lockSel = l;
    repeat (3) @(negedge clk);
    tickNo = 0; lastFall = -1; bitNo = 0; lockAt = 0; lost = 0;
    lastRx = 1'b0; prevClk = 1'b1; expQ.delete();
    chk(recClk == 1'b1, "R1 reset recClk", recClk, 1);
    chk(recData == 1'b0, "R1 reset recData", recData, 0);
    for (int k = 0; k < nBits; k++)
      bits[k] = (!randTail || k < 30) ? ((k % 2) == 0) : 1'($urandom_range(0, 1));
    rstN = 1'b1;
    total = firstT + 64 * nBits + 80;
    r = 1'b0;
    for (int t = 1; t < total; t++) begin
      if (t >= firstT && (t - firstT) / 64 < nBits) r = bits[(t - firstT) / 64];
      tickOnce(r);
    end
    // R3: idle clocks with tickEn low leave the outputs untouched
    begin
      bit c0, d0;
      c0 = recClk; d0 = recData;
      @(negedge clk); rxIn = ~rxIn;
      repeat (5) @(negedge clk);
      chk(recClk == c0 && recData == d0, "R3 idle hold", {recClk, recData}, {c0, d0});
    end
    chk(lockAt > 0 && lockAt <= lockLimit, "R8 lock bound", lockAt, lockLimit);
    chk(!lost, "R8 stays locked", lost, 0);
    if (lockExact > 0) chk(lockAt == lockExact, "R5/R6 lock transition", lockAt, lockExact);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    runScen(1'b1, 1'b0, 96, 60, 1'b0, 18, 5);      // error +31, big steps
    runScen(1'b1, 1'b1, 97, 70, 1'b0, 50, 8);      // error -32, small steps
    runScen(1'b1, 1'b0, $urandom_range(40, 103), 60, 1'b1, 18, 0);
    runScen(1'b1, 1'b1, $urandom_range(40, 103), 70, 1'b1, 50, 0);
    runScen(1'b0, 1'b0, 96, 60, 1'b1, 28, 28);     // slow only from +31
    runScen(1'b0, 1'b1, $urandom_range(40, 103), 60, 1'b1, 60, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule